// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block gives the verdict, keep or drop, for each incoming Ethernet frame. The verdict depends only on the frame's 48-bit destination address. The address is compared with eight exact-match slots. Group (multicast) addresses can also pass through a 64-bin hash table. A pass-everything mode and a broadcast block bit complete the policy. Parsing the frame and checking its FCS happen elsewhere. The receive path presents the address together with a one-cycle strobe. The verdict comes back on a registered output at a fixed latency.

Software sets up the filter through a single write-only register port. That port carries the mode bits, the two 32-bit halves of the hash table and a low/high word pair for each slot. A slot changes only when its high word is written, so a frame never sees a slot that is half updated. The usual arrangement is to put the station's own unicast address in slot 0 and to use the remaining slots for more unicast or group addresses. Group addresses that do not fit in the slots go into the hash table.

Top module: `rxaf_filter`

## Requirements
- R1: After reset, all configuration is zero. This means no slot matches, the hash bins are empty and every mode bit is off, so only broadcast frames are kept. `dec_valid` is low.
- R2: When `da_valid` is high in cycle n, `dec_valid` is high in cycle n+2 and not in cycle n+1. Every strobe produces exactly one verdict, and strobes in consecutive cycles give verdicts in consecutive cycles, in the same order.
- R3: The configuration address map is as follows:
  - Address 0 is the mode word. Bit 0 is accept-all, bit 1 is hash enable, bit 2 is broadcast block and bit 3 is exact-match enable.
  - Address 1 holds hash bins 31..0.
  - Address 2 holds hash bins 63..32.
  - Writes to any address outside the map have no effect.
- R4: Address byte k of a frame is carried on `da_addr[8k+7:8k]`, where byte 0 is the first byte on the wire. Slot i has a low word at address 16+2i, which holds bytes 3..0 with byte 0 in bits 7:0. Its high word is at address 17+2i and holds bytes 5..4 in bits 15:0.
- R5: A low-word write is held in a staging register and leaves the slot unchanged. A high-word write loads the slot with that high word together with the most recently staged low word.
- R6: With exact-match enable set, a frame is kept when its address equals any of the eight slots, including slot 7.
- R7: With exact-match enable clear, slot contents never cause a frame to be kept.
- R8: The hash bin is 6 bits wide. Address bits are taken from byte 0 to byte 5, least significant bit first. Bit number n in that order is XORed into bin bit n mod 6.
- R9: A group address is one with `da_addr[0]`=1 that is not all ones. Such a frame is kept when hash enable is set and its bin bit is 1; bins 0..31 read the low word and bins 32..63 read the high word. Unicast frames never pass through the hash table.
- R10: With hash enable set and both hash words all ones, every group frame is kept.
- R11: The all-ones broadcast address is kept unless broadcast block is set. Broadcast block also overrides the hash path.
- R12: With accept-all set, every frame is kept, including a blocked broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 6 | Configuration word address |
| cfg_wr_data | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe, one cycle per frame |
| da_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Verdict strobe, two cycles after `da_valid` |
| dec_accept | output | 1 | Verdict: 1 keeps the frame, 0 drops it |

## Verification
The verdict for a strobe in cycle n becomes visible in cycle n+2. Each frame task therefore drives the strobe for one cycle and then checks `dec_valid` twice: it must be low one cycle later and high, with the expected `dec_accept`, the cycle after that. A configuration write takes effect at the edge that captures it. Every frame is launched after that edge, so the verdict always reflects the new settings. A burst of three back-to-back strobes checks that the verdicts arrive one per cycle, in order, and that `dec_valid` falls right after the last one.

// File: rtl/rxaf_pkg.sv
`timescale 1ns/1ps
package rxaf_pkg;
  localparam int MAC_W     = 48;
  localparam int HASH_W    = 6;
  localparam int HASH_BINS = 1 << HASH_W;
  localparam int WORD_W    = 32;
  localparam int MODE_W    = 4;

  // Mode word layout, MSB first: exact enable, broadcast block, hash enable, accept-all
  typedef struct packed {
    logic exact_en;
    logic bcast_block;
    logic hash_en;
    logic accept_all;
  } mode_t;

  // XOR-fold of all address bits into a bin index; bit n lands in bin bit n mod HASH_W
  function automatic logic [HASH_W-1:0] fold_hash(input logic [MAC_W-1:0] a);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int n = 0; n < MAC_W; n++) begin
      h[n % HASH_W] = h[n % HASH_W] ^ a[n];
    end
    return h;
  endfunction

  function automatic logic is_broadcast(input logic [MAC_W-1:0] a);
    return &a;
  endfunction

  function automatic logic is_group(input logic [MAC_W-1:0] a);
    return a[0];
  endfunction
endpackage

// File: rtl/rxaf_cfg_regs.sv
`timescale 1ns/1ps
module rxaf_cfg_regs
  import rxaf_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CFG_AW    = 6,
  parameter int SLOT_BASE = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [CFG_AW-1:0]                  wr_addr,
  input  logic [WORD_W-1:0]                  wr_data,
  output mode_t                              mode_q,
  output logic [HASH_BINS-1:0]               hash_q,
  output logic [NUM_SLOTS-1:0][MAC_W-1:0]    slot_q
);
  localparam int HI_W = MAC_W - WORD_W;
  localparam logic [CFG_AW-1:0] MODE_ADDR = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] HLO_ADDR  = CFG_AW'(1);
  localparam logic [CFG_AW-1:0] HHI_ADDR  = CFG_AW'(2);

  logic                 mode_sel, hlo_sel, hhi_sel;
  logic [NUM_SLOTS-1:0] low_sel, high_sel;
  logic                 mapped_wr, unmapped_wr;
  logic [WORD_W-1:0]    stage_q;

  assign mode_sel = wr_en && (wr_addr == MODE_ADDR);
  assign hlo_sel  = wr_en && (wr_addr == HLO_ADDR);
  assign hhi_sel  = wr_en && (wr_addr == HHI_ADDR);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_dec
    assign low_sel[i]  = wr_en && (wr_addr == CFG_AW'(SLOT_BASE + 2*i));
    assign high_sel[i] = wr_en && (wr_addr == CFG_AW'(SLOT_BASE + 2*i + 1));
  end

  assign mapped_wr   = mode_sel | hlo_sel | hhi_sel | (|low_sel) | (|high_sel);
  assign unmapped_wr = wr_en & ~mapped_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      hash_q  <= '0;
      stage_q <= '0;
      slot_q  <= '0;
    end else begin
      if (mode_sel) mode_q <= mode_t'(wr_data[MODE_W-1:0]);
      if (hlo_sel)  hash_q[WORD_W-1:0] <= wr_data;
      if (hhi_sel)  hash_q[HASH_BINS-1:WORD_W] <= wr_data;
      if (|low_sel) stage_q <= wr_data;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (high_sel[i]) slot_q[i] <= {wr_data[HI_W-1:0], stage_q};
      end
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
    // R5
    slot_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      high_sel[i] |=> slot_q[i] == {$past(wr_data[HI_W-1:0]), $past(stage_q)});
    // R5
    low_only_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_sel[i] |=> $stable(slot_q[i]));
  end

  // R3
  unmapped_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_wr |=> $stable(mode_q) && $stable(hash_q) && $stable(slot_q));
endmodule

// File: rtl/rxaf_exact_bank.sv
`timescale 1ns/1ps
module rxaf_exact_bank
  import rxaf_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic [MAC_W-1:0]                 cand,
  input  logic [NUM_SLOTS-1:0][MAC_W-1:0]  slot_q,
  output logic [NUM_SLOTS-1:0]             hit_vec
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    assign hit_vec[i] = (cand == slot_q[i]);
  end
endmodule

// File: rtl/rxaf_verdict.sv
`timescale 1ns/1ps
module rxaf_verdict
  import rxaf_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  mode_t                  mode,
  input  logic [HASH_BINS-1:0]   hash_bits,
  input  logic [NUM_SLOTS-1:0]   hit_vec,
  input  logic [MAC_W-1:0]       cand,
  output logic                   accept,
  output logic                   bc_seen,
  output logic                   exact_path,
  output logic                   grp_seen
);
  logic [HASH_W-1:0] bin_idx;
  logic              hash_path, bcast_path;

  assign bin_idx    = fold_hash(cand);
  assign bc_seen    = is_broadcast(cand);
  assign grp_seen   = is_group(cand) && !bc_seen;
  assign exact_path = mode.exact_en && (|hit_vec);
  assign hash_path  = mode.hash_en && grp_seen && hash_bits[bin_idx];
  assign bcast_path = bc_seen && !mode.bcast_block;
  assign accept     = mode.accept_all | exact_path | hash_path | bcast_path;
endmodule

// File: rtl/rxaf_filter.sv
`timescale 1ns/1ps
module rxaf_filter
  import rxaf_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CFG_AW    = 6,
  parameter int SLOT_BASE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_wr_addr,
  input  logic [31:0]       cfg_wr_data,
  input  logic              da_valid,
  input  logic [47:0]       da_addr,
  output logic              dec_valid,
  output logic              dec_accept
);
  mode_t                            mode_q;
  logic [HASH_BINS-1:0]             hash_q;
  logic [NUM_SLOTS-1:0][MAC_W-1:0]  slot_q;
  logic [NUM_SLOTS-1:0]             hit_vec;
  logic                             s1_valid;
  logic [MAC_W-1:0]                 s1_addr;
  logic                             accept_now, bc_seen, exact_path, grp_seen;

  rxaf_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .CFG_AW(CFG_AW), .SLOT_BASE(SLOT_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .mode_q(mode_q), .hash_q(hash_q), .slot_q(slot_q)
  );

  // Stage 1: capture the address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_addr  <= '0;
    end else begin
      s1_valid <= da_valid;
      if (da_valid) s1_addr <= da_addr;
    end
  end

  rxaf_exact_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
    .cand(s1_addr), .slot_q(slot_q), .hit_vec(hit_vec)
  );

  rxaf_verdict #(.NUM_SLOTS(NUM_SLOTS)) u_verdict (
    .mode(mode_q), .hash_bits(hash_q), .hit_vec(hit_vec), .cand(s1_addr),
    .accept(accept_now), .bc_seen(bc_seen), .exact_path(exact_path), .grp_seen(grp_seen)
  );

  // Stage 2: register the verdict
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= s1_valid;
      dec_accept <= s1_valid && accept_now;
    end
  end

  // R2
  stage1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> s1_valid);
  // R2
  verdict_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> dec_valid);
  // R2
  no_spurious_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !dec_valid && !dec_accept);
  // R12
  accept_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && mode_q.accept_all |=> dec_accept);
  // R11
  bcast_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && bc_seen && mode_q.bcast_block && !mode_q.accept_all && !exact_path
    |=> !dec_accept);
  // R9
  unicast_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && !grp_seen && !bc_seen && !mode_q.accept_all && !exact_path
    |=> !dec_accept);
endmodule

// File: tb/tb_rxaf_filter.sv
`timescale 1ns/1ps
module tb_rxaf_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [5:0]  cfg_wr_addr = '0;
  logic [31:0] cfg_wr_data = '0;
  logic        da_valid = 1'b0;
  logic [47:0] da_addr = '0;
  logic        dec_valid, dec_accept;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  always #4 clk = ~clk;

  rxaf_filter dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .da_valid(da_valid), .da_addr(da_addr),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench-side bin: walk bytes 0..5, bits LSB first, rotating target bin bit
  function automatic logic [5:0] ref_bin(input logic [47:0] a);
    logic [5:0] h = '0;
    int p = 0;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] octet = a[8*b +: 8];
      for (int k = 0; k < 8; k++) begin
        h[p] = h[p] ^ octet[k];
        p = (p == 5) ? 0 : p + 1;
      end
    end
    return h;
  endfunction

  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic load_slot(input int i, input logic [47:0] a);
    cfg_write(6'(16 + 2*i), a[31:0]);
    cfg_write(6'(17 + 2*i), {16'h0, a[47:32]});
  endtask

  task automatic send(input logic [47:0] a, input bit exp, input string req);
    @(negedge clk);
    da_valid = 1'b1; da_addr = a;
    @(negedge clk);
    da_valid = 1'b0;
    check(dec_valid == 1'b0, "R2 early", 48'(dec_valid), 48'd0);
    @(negedge clk);
    check(dec_valid == 1'b1, "R2 due", 48'(dec_valid), 48'd1);
    check(dec_accept == exp, req, 48'(dec_accept), 48'(exp));
  endtask

  task automatic t_reset();
    check(dec_valid == 1'b0, "R1 valid low", 48'(dec_valid), 48'd0);
    send(BCAST, 1'b1, "R1 bcast kept");
    send(48'h6655_4433_2210, 1'b0, "R1 unicast dropped");
    send(48'h0000_0000_0000, 1'b0, "R1 zero address vs zero slots");
  endtask

  task automatic t_exact();
    logic [47:0] st = 48'h0A0B_0C0D_0E10;
    logic [47:0] s7 = 48'h1122_3344_5566;
    load_slot(0, st);
    load_slot(7, s7);
    cfg_write(6'd0, 32'h8);
    send(st, 1'b1, "R6 R4 slot0 hit");
    send(st ^ 48'h0100_0000_0000, 1'b0, "R6 byte5 miss");
    send(st ^ 48'h0000_0000_0100, 1'b0, "R4 byte1 miss");
    send(s7, 1'b1, "R6 slot7 hit");
    cfg_write(6'd0, 32'h0);
    send(st, 1'b0, "R7 disabled slot0");
    send(s7, 1'b0, "R7 disabled slot7");
  endtask

  task automatic t_atomic();
    logic [47:0] a_old = 48'h2000_0000_0A02;
    logic [47:0] a_new = 48'h3000_0000_0B04;
    load_slot(3, a_old);
    cfg_write(6'd0, 32'h8);
    cfg_write(6'd22, a_new[31:0]);
    send(a_old, 1'b1, "R5 low staged only, old kept");
    send(a_new, 1'b0, "R5 new not yet live");
    cfg_write(6'd23, {16'h0, a_new[47:32]});
    send(a_new, 1'b1, "R5 new live after high");
    send(a_old, 1'b0, "R5 old replaced");
  endtask

  task automatic t_hash();
    logic [47:0] hi_a = '0, lo_a = '0, uni;
    bit got_hi = 0, got_lo = 0;
    logic [5:0] bh, bl;
    for (int v = 0; v < 256; v++) begin
      logic [47:0] c = {8'(v), 40'h5E_0000_0001};
      logic [5:0] bn = ref_bin(c);
      if (!got_hi && bn >= 6'd32) begin hi_a = c; got_hi = 1; end
      if (!got_lo && bn < 6'd32)  begin lo_a = c; got_lo = 1; end
    end
    bh = ref_bin(hi_a); bl = ref_bin(lo_a);
    cfg_write(6'd0, 32'h2);
    cfg_write(6'd1, 32'h0000_0002);
    send(48'h0000_0000_0001, 1'b1, "R8 bin 1 known");
    send(48'h0000_0000_0041, 1'b0, "R8 bin 0 empty");
    cfg_write(6'd1, 32'h0);
    cfg_write(6'd2, 32'h1 << (bh - 6'd32));
    send(hi_a, 1'b1, "R9 R8 high word bin");
    send(lo_a, 1'b0, "R9 low bin empty");
    cfg_write(6'd1, 32'h1 << bl);
    send(lo_a, 1'b1, "R9 R8 low word bin");
    uni = hi_a ^ 48'h41;
    check(ref_bin(uni) == bh, "R8 bench bin equal", 48'(ref_bin(uni)), 48'(bh));
    send(uni, 1'b0, "R9 unicast same bin dropped");
    cfg_write(6'd0, 32'h0);
    send(hi_a, 1'b0, "R9 hash disabled");
  endtask

  task automatic t_allmulti();
    cfg_write(6'd0, 32'h2);
    cfg_write(6'd1, 32'hFFFF_FFFF);
    cfg_write(6'd2, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) begin
      send({8'(k*37), 32'hA5A5_1234, 8'(2*k + 1)}, 1'b1, "R10 group kept");
    end
    send(48'h1234_5678_9A02, 1'b0, "R10 unicast still dropped");
  endtask

  task automatic t_bcast();
    cfg_write(6'd0, 32'h4);
    send(BCAST, 1'b0, "R11 blocked");
    cfg_write(6'd0, 32'h6);
    send(BCAST, 1'b0, "R11 block beats hash");
    cfg_write(6'd0, 32'h0);
    send(BCAST, 1'b1, "R11 unblocked");
  endtask

  task automatic t_promisc();
    cfg_write(6'd0, 32'h5);
    send(48'hDEAD_BEEF_0042, 1'b1, "R12 unicast kept");
    send(BCAST, 1'b1, "R12 blocked bcast kept");
    cfg_write(6'd0, 32'h0);
  endtask

  task automatic t_unmapped();
    cfg_write(6'd3, 32'hFFFF_FFFF);
    cfg_write(6'd15, 32'hFFFF_FFFF);
    cfg_write(6'd32, 32'hFFFF_FFFF);
    cfg_write(6'd63, 32'hFFFF_FFFF);
    send(48'h7777_8888_9902, 1'b0, "R3 mode untouched");
    send(48'h0000_0000_0001, 1'b0, "R3 hash enable untouched");
    cfg_write(6'd0, 32'h1);
    send(48'h7777_8888_9902, 1'b0 | 1'b1, "R3 mode bit0 accept-all");
    cfg_write(6'd0, 32'h0);
  endtask

  task automatic t_burst();
    logic [47:0] st = 48'h0A0B_0C0D_0E10;
    cfg_write(6'd0, 32'h8);
    @(negedge clk); da_valid = 1'b1; da_addr = st;
    @(negedge clk); da_addr = 48'h0000_0000_0002;
    check(dec_valid == 1'b0, "R2 burst gap", 48'(dec_valid), 48'd0);
    @(negedge clk); da_addr = BCAST;
    check(dec_valid && dec_accept, "R2 burst v1", {46'd0, dec_valid, dec_accept}, 48'd3);
    @(negedge clk); da_valid = 1'b0;
    check(dec_valid && !dec_accept, "R2 burst v2", {46'd0, dec_valid, dec_accept}, 48'd2);
    @(negedge clk);
    check(dec_valid && dec_accept, "R2 burst v3", {46'd0, dec_valid, dec_accept}, 48'd3);
    @(negedge clk);
    check(!dec_valid, "R2 burst end", 48'(dec_valid), 48'd0);
    cfg_write(6'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exact();
    t_atomic();
    t_hash();
    t_allmulti();
    t_bcast();
    t_promisc();
    t_unmapped();
    t_burst();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule